// File: doc/BRIEF.md
# Isochronous OUT Endpoint Ping-Pong Receive Buffer

This block is the receive side of one isochronous OUT endpoint in a full-speed USB device controller. The packet engine delivers each OUT data packet to it as a start pulse, a run of byte strobes, and an end pulse that carries the CRC verdict. The block keeps two packet buffers of `DEPTH` bytes each. Every packet goes into the next buffer in turn. A packet that passes its CRC check is then held for the CPU. A packet that fails is thrown away. If both buffers are still occupied when a packet arrives, the packet is dropped and an overflow is recorded.

The CPU always reads bytes from the oldest complete buffer. `cpu_rdata` shows the byte at the current position, and each `cpu_rd` pulse moves to the next byte. `cpu_rem` gives the number of bytes still unread in that buffer. A status register reports three flags: a service flag while any complete packet is waiting, a write-one-to-clear flag for packet completion, and a write-one-to-clear flag for overflow. An interrupt request combines the two event flags and is gated by an enable input.

Top module: `iso_rx_pingpong`

## Requirements
- R1: When a packet ends with `pkt_crc_ok`=1, `csr_rdata` bit 0 (service) reads 1 from the cycle after `pkt_end`, and the stored bytes are later returned in arrival order.
- R2: Full packets of `DEPTH` (256) bytes, short packets and zero-length packets all count as complete. Bytes beyond `DEPTH` are discarded, so a longer packet reports `cpu_rem` = `DEPTH`.
- R3: The CPU reads the oldest complete buffer first. While a buffer is being read, `cpu_rem` gives its unread byte count and `cpu_rdata` gives its current byte. A `cpu_rd` on the last byte releases the buffer. A zero-length buffer is released by one `cpu_rd`. When service is 0, `cpu_rem` and `cpu_rdata` read 0.
- R4: The service flag stays 1 until both buffers have been fully drained.
- R5: `csr_rdata` bit 1 (packet complete) sets in the cycle after `pkt_end` of every packet that was stored. It clears when `csr_wr` is pulsed with `csr_wdata` bit 1 = 1. If a set and a clear fall in the same cycle, the set wins.
- R6: A `pkt_start` that arrives while both buffers hold complete packets drops the whole packet. `csr_rdata` bit 2 (overflow) then reads 1 the next cycle, and the buffered data is left unchanged.
- R7: The overflow flag clears only when `csr_wr` is pulsed with `csr_wdata` bit 2 = 1. Writing 0 bits has no effect. `csr_rdata` bits 7..3 always read 0.
- R8: A packet that ends with `pkt_crc_ok`=0 frees its buffer without setting service. The packet-complete flag still sets.
- R9: `irq` equals `irq_en` AND (packet-complete OR overflow), taken from the flags as they are registered.
- R10: A `pkt_start` that arrives while a packet is still being filled restarts the fill in the same buffer, and the earlier partial bytes are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | First-cycle pulse of an OUT data packet |
| pkt_vld | input | 1 | Byte strobe for `pkt_data` |
| pkt_data | input | 8 | Received byte |
| pkt_end | input | 1 | Last-cycle pulse of the packet |
| pkt_crc_ok | input | 1 | CRC verdict, sampled with `pkt_end` |
| cpu_rd | input | 1 | Advance the read position by one byte |
| cpu_rdata | output | 8 | Current byte of the oldest complete buffer |
| cpu_rem | output | 9 | Unread bytes left in that buffer |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Write data; a 1 in bit 1 or bit 2 clears that flag |
| csr_rdata | output | 8 | {5'b0, overflow, packet complete, service} |
| irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The flags and `cpu_rem` are registered, so their effect shows one cycle after the stimulus that causes it. `cpu_rdata` and `irq` are combinational from registered state. The bench drives inputs on the falling edge and samples at the next falling edge, which is exactly one rising edge later, so every flag, byte and count is compared in the cycle it becomes due. A bench model tracks how many buffers are occupied, the order of the stored packets and the two event flags, and it predicts each expected value from the requirements.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
    typedef enum logic [1:0] {
        BK_FREE = 2'd0,
        BK_FILL = 2'd1,
        BK_FULL = 2'd2
    } bank_st_e;

    localparam int CSR_W   = 8;
    localparam int CSR_SVC = 0;
    localparam int CSR_RPC = 1;
    localparam int CSR_OVF = 2;
endpackage

// File: rtl/iso_rx_bank.sv
module iso_rx_bank
    import iso_rx_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              close_ok,
    input  logic              close_bad,
    input  logic              release_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output bank_st_e          st_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        bank_st_e         st;
        logic [LEN_W-1:0] len;
    } bank_s;

    bank_s bank_d, bank_q;
    logic  do_wr;
    logic [7:0] mem [DEPTH];

    always_comb begin
        bank_d = bank_q;
        do_wr  = 1'b0;
        if (claim) begin
            bank_d.st  = BK_FILL;
            bank_d.len = '0;
        end else if (bank_q.st == BK_FILL) begin
            if (close_bad) begin
                bank_d.st  = BK_FREE;
                bank_d.len = '0;
            end else begin
                if (wr_en && (bank_q.len < LEN_W'(DEPTH))) begin
                    do_wr      = 1'b1;
                    bank_d.len = bank_q.len + 1'b1;
                end
                if (close_ok) bank_d.st = BK_FULL;
            end
        end else if ((bank_q.st == BK_FULL) && release_i) begin
            bank_d.st  = BK_FREE;
            bank_d.len = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '{st: BK_FREE, len: '0};
        else        bank_q <= bank_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[bank_q.len[ADDR_W-1:0]] <= wr_data;
    end

    assign st_o    = bank_q.st;
    assign len_o   = bank_q.len;
    assign rd_data = mem[rd_addr];

    // R1: a buffer only becomes complete right after a good close
    p_full_after_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == BK_FULL && $past(bank_q.st) != BK_FULL) |-> $past(close_ok));

    // R2: stored length never passes the buffer size
    p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.len <= LEN_W'(DEPTH));
endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
    import iso_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_rpc,
    input  logic             set_ovf,
    input  logic             svc,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    input  logic             irq_en,
    output logic [CSR_W-1:0] rdata,
    output logic             irq
);
    typedef struct packed {
        logic rpc;
        logic ovf;
    } flag_s;

    flag_s flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_rpc)                   flag_d.rpc = 1'b1;
        else if (wr && wdata[CSR_RPC]) flag_d.rpc = 1'b0;
        if (set_ovf)                   flag_d.ovf = 1'b1;
        else if (wr && wdata[CSR_OVF]) flag_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    always_comb begin
        rdata          = '0;
        rdata[CSR_SVC] = svc;
        rdata[CSR_RPC] = flag_q.rpc;
        rdata[CSR_OVF] = flag_q.ovf;
    end

    assign irq = irq_en & (flag_q.rpc | flag_q.ovf);

    p_rpc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_rpc |=> flag_q.rpc);

    p_rpc_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[CSR_RPC] && !set_rpc) |=> !flag_q.rpc);

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ovf && !(wr && wdata[CSR_OVF])) |=> (flag_q.ovf == $past(flag_q.ovf)));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: rtl/iso_rx_pingpong.sv
module iso_rx_pingpong
    import iso_rx_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_vld,
    input  logic [7:0]       pkt_data,
    input  logic             pkt_end,
    input  logic             pkt_crc_ok,
    input  logic             cpu_rd,
    output logic [7:0]       cpu_rdata,
    output logic [LEN_W-1:0] cpu_rem,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             irq_en,
    output logic             irq
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic              wr_bank;
        logic              rd_bank;
        logic [ADDR_W-1:0] rd_ptr;
        logic              dropping;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    bank_st_e         bank_st  [NBANK];
    logic [LEN_W-1:0] bank_len [NBANK];
    logic [7:0]       bank_rd  [NBANK];
    logic [NBANK-1:0] claim_v, wr_v, ok_v, bad_v, rel_v;
    logic             set_rpc, set_ovf, svc, head_full;

    always_comb begin
        ctl_d   = ctl_q;
        claim_v = '0;
        wr_v    = '0;
        ok_v    = '0;
        bad_v   = '0;
        rel_v   = '0;
        set_rpc = 1'b0;
        set_ovf = 1'b0;

        // packet side
        if (pkt_start) begin
            if (bank_st[ctl_q.wr_bank] != BK_FULL) begin
                claim_v[ctl_q.wr_bank] = 1'b1;
                ctl_d.dropping         = 1'b0;
            end else begin
                set_ovf        = 1'b1;
                ctl_d.dropping = 1'b1;
            end
        end else begin
            if (pkt_vld && !ctl_q.dropping) wr_v[ctl_q.wr_bank] = 1'b1;
            if (pkt_end) begin
                ctl_d.dropping = 1'b0;
                if (!ctl_q.dropping && bank_st[ctl_q.wr_bank] == BK_FILL) begin
                    set_rpc = 1'b1;
                    if (pkt_crc_ok) begin
                        ok_v[ctl_q.wr_bank] = 1'b1;
                        ctl_d.wr_bank       = ~ctl_q.wr_bank;
                    end else begin
                        bad_v[ctl_q.wr_bank] = 1'b1;
                    end
                end
            end
        end

        // CPU side
        head_full = (bank_st[ctl_q.rd_bank] == BK_FULL);
        if (cpu_rd && head_full) begin
            if (({1'b0, ctl_q.rd_ptr} + 1'b1) >= bank_len[ctl_q.rd_bank]) begin
                rel_v[ctl_q.rd_bank] = 1'b1;
                ctl_d.rd_ptr         = '0;
                ctl_d.rd_bank        = ~ctl_q.rd_bank;
            end else begin
                ctl_d.rd_ptr = ctl_q.rd_ptr + 1'b1;
            end
        end

        svc = (bank_st[0] == BK_FULL) || (bank_st[1] == BK_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        iso_rx_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .claim    (claim_v[g]),
            .wr_en    (wr_v[g]),
            .wr_data  (pkt_data),
            .close_ok (ok_v[g]),
            .close_bad(bad_v[g]),
            .release_i(rel_v[g]),
            .rd_addr  (ctl_q.rd_ptr),
            .st_o     (bank_st[g]),
            .len_o    (bank_len[g]),
            .rd_data  (bank_rd[g])
        );
    end

    assign cpu_rdata = head_full ? bank_rd[ctl_q.rd_bank] : 8'd0;
    assign cpu_rem   = head_full ? (bank_len[ctl_q.rd_bank] - {1'b0, ctl_q.rd_ptr}) : '0;

    iso_rx_csr u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_rpc(set_rpc),
        .set_ovf(set_ovf),
        .svc    (svc),
        .wr     (csr_wr),
        .wdata  (csr_wdata),
        .irq_en (irq_en),
        .rdata  (csr_rdata),
        .irq    (irq)
    );

    // R6: a start with the target buffer still held shows overflow next cycle
    p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && bank_st[ctl_q.wr_bank] == BK_FULL) |=> csr_rdata[CSR_OVF]);

    // R3: buffers are handed back one at a time
    p_one_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_v));
endmodule

// File: tb/iso_rx_pingpong_test.sv
module iso_rx_pingpong_test;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 0, pkt_vld = 0, pkt_end = 0, pkt_crc_ok = 0;
    logic [7:0] pkt_data = '0;
    logic       cpu_rd = 0;
    logic [7:0] cpu_rdata;
    logic [8:0] cpu_rem;
    logic       csr_wr = 0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       irq_en = 1'b1;
    logic       irq;

    always #10 clk = ~clk;

    iso_rx_pingpong uut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_vld(pkt_vld),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rem(cpu_rem),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .irq_en(irq_en), .irq(irq)
    );

    int nvec = 0;
    int nbad = 0;

    // reference model
    logic [7:0] m_buf [2][DEPTH];
    int         m_len [2];
    int         m_head = 0, m_tail = 0, m_occ = 0;
    bit         m_rpc = 0, m_ovf = 0;
    logic [7:0] pk [DEPTH+8];

    task automatic chk(bit ok, string req, int act, int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_csr();
        return {5'b0, m_ovf, m_rpc, (m_occ > 0)};
    endfunction

    function automatic bit exp_irq();
        return irq_en & (m_rpc | m_ovf);
    endfunction

    task automatic check_flags(string req);
        chk(csr_rdata == exp_csr(), req, csr_rdata, exp_csr());
        chk(irq == exp_irq(), "R9 irq", irq, exp_irq());
    endtask

    task automatic model_pkt(int n, bit ok);
        if (m_occ == 2) begin
            m_ovf = 1;
        end else begin
            m_rpc = 1;
            if (ok) begin
                m_len[m_tail] = (n > DEPTH) ? DEPTH : n;
                for (int i = 0; i < m_len[m_tail]; i++) m_buf[m_tail][i] = pk[i];
                m_tail ^= 1;
                m_occ++;
            end
        end
    endtask

    // entered and left on a falling edge; flags due at exit
    task automatic send_pkt(int n, bit ok);
        for (int i = 0; i < n; i++) pk[i] = 8'($urandom);
        pkt_start = 1;
        @(negedge clk) pkt_start = 0;
        for (int i = 0; i < n; i++) begin
            pkt_vld = 1; pkt_data = pk[i];
            @(negedge clk);
        end
        pkt_vld = 0; pkt_end = 1; pkt_crc_ok = ok;
        @(negedge clk) pkt_end = 0; pkt_crc_ok = 0;
        model_pkt(n, ok);
    endtask

    task automatic drain_one(string req);
        int n;
        n = m_len[m_head];
        chk(cpu_rem == 9'(n), {req, " remaining count"}, cpu_rem, n);
        if (n == 0) begin
            cpu_rd = 1;
            @(negedge clk) cpu_rd = 0;
        end else begin
            for (int i = 0; i < n; i++) begin
                if (i == 0 || i == n - 1 || (i % 7) == 3)
                    chk(cpu_rdata == m_buf[m_head][i], {req, " read byte"}, cpu_rdata, m_buf[m_head][i]);
                cpu_rd = 1;
                @(negedge clk) cpu_rd = 0;
            end
        end
        m_head ^= 1;
        m_occ--;
    endtask

    task automatic csr_write(logic [7:0] v);
        csr_wr = 1; csr_wdata = v;
        @(negedge clk) csr_wr = 0; csr_wdata = 0;
        if (v[1]) m_rpc = 0;
        if (v[2]) m_ovf = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(csr_rdata == 8'h00, "R7 reset status", csr_rdata, 0);
        chk(irq == 1'b0, "R9 reset irq", irq, 0);
        chk(cpu_rem == 0, "R3 reset remaining", cpu_rem, 0);

        // zero-length packet
        send_pkt(0, 1);
        check_flags("R2 zero-length complete");
        irq_en = 0; #1;
        chk(irq == 1'b0, "R9 irq disabled", irq, 0);
        irq_en = 1; #1;
        chk(irq == 1'b1, "R9 irq enabled", irq, 1);

        // write of zeros has no effect, then clear packet complete
        csr_write(8'h00);
        check_flags("R7 zero write no effect");
        csr_write(8'h02);
        check_flags("R5 packet complete cleared");

        // full-size packet fills the second buffer, third packet overflows
        send_pkt(DEPTH, 1);
        check_flags("R1 full packet stored");
        send_pkt(20, 1);
        check_flags("R6 overflow set");
        csr_write(8'hFC);
        check_flags("R7 overflow cleared, reserved zero");

        // drain oldest first, service stays until both drained
        drain_one("R3 zero-length release");
        check_flags("R4 service stays with one buffer left");
        drain_one("R6 data unchanged after drop");
        check_flags("R4 service clears when drained");
        chk(cpu_rem == 0, "R3 idle remaining", cpu_rem, 0);

        // bad CRC
        csr_write(8'h06);
        send_pkt(9, 0);
        check_flags("R8 bad CRC leaves service clear");

        // oversize packet truncated
        send_pkt(DEPTH + 4, 1);
        check_flags("R2 oversize stored");
        drain_one("R2 oversize truncated");

        // restart mid-fill
        pkt_start = 1;
        @(negedge clk) pkt_start = 0;
        for (int i = 0; i < 5; i++) begin
            pkt_vld = 1; pkt_data = 8'hA0 + 8'(i);
            @(negedge clk);
        end
        pkt_vld = 0;
        send_pkt(3, 1);
        check_flags("R10 restarted packet complete");
        drain_one("R10 only restarted bytes kept");

        // set wins over clear in the same cycle
        csr_write(8'h02);
        send_pkt(2, 1);
        pkt_start = 1;
        @(negedge clk) pkt_start = 0;
        pkt_vld = 1; pk[0] = 8'h5A; pkt_data = 8'h5A;
        @(negedge clk) pkt_vld = 0;
        m_rpc = 0;
        pkt_end = 1; pkt_crc_ok = 1; csr_wr = 1; csr_wdata = 8'h02;
        @(negedge clk) pkt_end = 0; pkt_crc_ok = 0; csr_wr = 0; csr_wdata = 0;
        model_pkt(1, 1);
        check_flags("R5 set wins over clear");
        drain_one("R1 first of pair");
        drain_one("R1 second of pair");

        // random mix
        for (int it = 0; it < 160; it++) begin
            int op;
            op = int'($urandom % 5);
            if (op <= 1) begin
                int n;
                n = ($urandom % 8 == 0) ? DEPTH : int'($urandom % 40);
                send_pkt(n, ($urandom % 8) != 0);
                check_flags("R1 random packet flags");
            end else if (op == 2 || op == 3) begin
                if (m_occ > 0) begin
                    drain_one("R3 random drain");
                    check_flags("R4 random drain flags");
                end
            end else begin
                irq_en = 1'($urandom);
                csr_write(8'($urandom));
                check_flags("R7 random status write");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule